// File: doc/BRIEF.md
# Opcode Fetch and Refresh Sequencer

This block produces the four-state instruction-fetch machine cycle of an 8-bit processor bus and keeps the dynamic-memory refresh counter. A fetch request latches the program counter, which goes out on the address bus for the first two states. The opcode-fetch marker is asserted over those states, and the memory-request and read strobes are asserted from the middle of the first state. The opcode is captured from the data bus on the edge that opens the third state.

The third and fourth states are a refresh window. The address bus carries the interrupt-vector byte in its upper half and the refresh counter in its lower half, and the refresh strobe is held low. The memory-request strobe pulses low again for one clock, running from the middle of the third state to the middle of the fourth. When the fetch completes, the counter advances in its low seven bits only, and its top bit keeps whatever value was last written.

A done pulse marks the fourth state. A request present in that state starts the next fetch on the following clock, so fetches can run back to back with no idle clock between them.

Top module: `ofr_top`

## Requirements
- R1: After reset, addrOut is 0, m1N, mreqN, rdN and rfshN are all 1, fetchDone is 0, and the refresh counter is 0.
- R2: The clock edge that samples startFetch high while idle begins state T1. pcIn is latched on that edge and is driven on addrOut through T1 and T2, whatever pcIn does afterwards.
- R3: m1N is 0 for exactly T1 and T2 and is 1 at every other time.
- R4: mreqN and rdN are 1 in the first half of T1 and go to 0 at the falling edge inside T1. They stay 0 through the end of T2.
- R5: opcodeOut takes the value of dataIn on the rising edge that begins T3 and then holds that value until the next such edge.
- R6: During T3 and T4, rfshN is 0 and addrOut equals {vecIn, R}, where R is the refresh counter value before this fetch's increment. At all other times rfshN is 1.
- R7: In the refresh window rdN stays 1. mreqN is 1 in the first half of T3, is 0 from the falling edge in T3 to the falling edge in T4, and is 1 in the second half of T4.
- R8: The edge that ends T4 increments bits 6:0 of R modulo 128 and leaves bit 7 unchanged. For example, 0x7F becomes 0x00 and 0xFF becomes 0x80.
- R9: rLoadEn high at a clock edge writes all 8 bits of rLoadVal into R, including bit 7.
- R10: If a load and the post-fetch increment fall on the same edge, R takes the loaded value with no increment.
- R11: fetchDone is 1 for exactly the T4 clock. If startFetch is high during T4, T1 of the next fetch begins on the very next clock.
- R12: startFetch is ignored during T1, T2 and T3. It starts no extra fetch and does not change the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states change on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startFetch | input | 1 | Fetch request, sampled while idle or in T4 |
| pcIn | input | 16 | Program counter to fetch from |
| vecIn | input | 8 | Interrupt-vector byte for the refresh address high half |
| rLoadEn | input | 1 | Write enable for the refresh counter |
| rLoadVal | input | 8 | Value written to the refresh counter |
| dataIn | input | 8 | Data bus input |
| addrOut | output | 16 | Address bus |
| m1N | output | 1 | Opcode-fetch marker, active low |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| opcodeOut | output | 8 | Captured opcode |
| fetchDone | output | 1 | One-clock pulse in T4 |

## Verification
A corrupted state register appears on m1N, rfshN or fetchDone in the same clock, because all three decode straight from the state. The half-state register that shapes mreqN and rdN is checked in each half of every state, so a wrong value there shows up within half a clock. A wrong refresh counter does not show up until the next fetch's T3, when it appears on the low address byte. For that reason the bench runs one fetch after every load, wrap and collision case to bring the counter out. The latched address and the captured opcode are each checked after their input has already been changed, so a path that should hold its value but instead follows the live input is caught within one state.

// File: rtl/ofr_pkg.sv
package ofr_pkg;

  // Fetch machine states; T1..T4 follow one another on rising edges.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } fetchState_t;

  // Strobes from control to datapath, all applied on the next rising edge
  // except refreshSel, which steers the address mux.
  typedef struct packed {
    logic latchPc;
    logic latchOp;
    logic bumpR;
    logic refreshSel;
  } ofrStrobe_t;

endpackage

// File: rtl/ofr_ctrl.sv
module ofr_ctrl
  import ofr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startFetch,
  output ofrStrobe_t strobe,
  output logic       m1N,
  output logic       mreqN,
  output logic       rdN,
  output logic       rfshN,
  output logic       fetchDone
);

  fetchState_t state, stateNext, halfState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Copy of the state taken on the falling edge; gives the half-clock strobes.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) halfState <= ST_IDLE;
    else       halfState <= state;
  end

  logic acceptStart;
  assign acceptStart = startFetch && (state == ST_IDLE || state == ST_T4);

  always_comb begin
    unique case (state)
      ST_IDLE: stateNext = acceptStart ? ST_T1 : ST_IDLE;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3:   stateNext = ST_T4;
      ST_T4:   stateNext = acceptStart ? ST_T1 : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  logic inT1Late, inT3Late, inT4Early, inRefresh;
  assign inT1Late  = (state == ST_T1) && (halfState == ST_T1);
  assign inT3Late  = (state == ST_T3) && (halfState == ST_T3);
  assign inT4Early = (state == ST_T4) && (halfState == ST_T3);
  assign inRefresh = (state == ST_T3) || (state == ST_T4);

  always_comb begin
    strobe.latchPc    = acceptStart;
    strobe.latchOp    = (state == ST_T2);
    strobe.bumpR      = (state == ST_T4);
    strobe.refreshSel = inRefresh;
  end

  assign m1N       = !((state == ST_T1) || (state == ST_T2));
  assign rdN       = !(inT1Late || (state == ST_T2));
  assign mreqN     = !(inT1Late || (state == ST_T2) || inT3Late || inT4Early);
  assign rfshN     = !inRefresh;
  assign fetchDone = (state == ST_T4);

endmodule

// File: rtl/ofr_dpath.sv
module ofr_dpath
  import ofr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ofrStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        pcIn,
  input  logic [ADDR_W-DATA_W-1:0] vecIn,
  input  logic                     rLoadEn,
  input  logic [DATA_W-1:0]        rLoadVal,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [ADDR_W-1:0]        addrOut,
  output logic [DATA_W-1:0]        opcodeOut
);

  localparam int CNT_W = DATA_W - 1;  // counting part of the refresh register

  logic [ADDR_W-1:0] pcHold;
  logic [DATA_W-1:0] opReg;
  logic [DATA_W-1:0] rReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcHold <= '0;
      opReg  <= '0;
    end else begin
      if (strobe.latchPc) pcHold <= pcIn;
      if (strobe.latchOp) opReg  <= dataIn;
    end
  end

  // Refresh register: a load beats the post-fetch step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rReg <= '0;
    else if (rLoadEn)      rReg <= rLoadVal;
    else if (strobe.bumpR) rReg <= {rReg[DATA_W-1], rReg[CNT_W-1:0] + CNT_W'(1)};
  end

  assign addrOut   = strobe.refreshSel ? {vecIn, rReg} : pcHold;
  assign opcodeOut = opReg;

endmodule

// File: rtl/ofr_top.sv
module ofr_top
  import ofr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startFetch,
  input  logic [ADDR_W-1:0]        pcIn,
  input  logic [ADDR_W-DATA_W-1:0] vecIn,
  input  logic                     rLoadEn,
  input  logic [DATA_W-1:0]        rLoadVal,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [ADDR_W-1:0]        addrOut,
  output logic                     m1N,
  output logic                     mreqN,
  output logic                     rdN,
  output logic                     rfshN,
  output logic [DATA_W-1:0]        opcodeOut,
  output logic                     fetchDone
);

  ofrStrobe_t strobe;

  ofr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startFetch (startFetch),
    .strobe     (strobe),
    .m1N        (m1N),
    .mreqN      (mreqN),
    .rdN        (rdN),
    .rfshN      (rfshN),
    .fetchDone  (fetchDone)
  );

  ofr_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pcIn      (pcIn),
    .vecIn     (vecIn),
    .rLoadEn   (rLoadEn),
    .rLoadVal  (rLoadVal),
    .dataIn    (dataIn),
    .addrOut   (addrOut),
    .opcodeOut (opcodeOut)
  );

endmodule

// File: rtl/ofr_checker.sv
module ofr_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrOut,
  input logic              m1N,
  input logic              mreqN,
  input logic              rdN,
  input logic              rfshN,
  input logic [DATA_W-1:0] opcodeOut,
  input logic              fetchDone
);

  AST_M1_RFSH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!m1N && !rfshN)); // R6

  AST_RD_QUIET_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> rdN); // R7

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> !fetchDone); // R11

  AST_DONE_IN_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |-> !rfshN); // R11

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && $past(!m1N)) |-> $stable(addrOut)); // R2

  AST_M1_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(m1N) |=> !m1N); // R3

  AST_OP_ONLY_AT_T3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(opcodeOut) |-> $fell(rfshN)); // R5

endmodule

bind ofr_top ofr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrOut   (addrOut),
  .m1N       (m1N),
  .mreqN     (mreqN),
  .rdN       (rdN),
  .rfshN     (rfshN),
  .opcodeOut (opcodeOut),
  .fetchDone (fetchDone)
);

// File: tb/ofr_top_bench.sv
module ofr_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startFetch = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  vecIn = '0;
  logic        rLoadEn = 1'b0;
  logic [7:0]  rLoadVal = '0;
  logic [7:0]  dataIn = '0;
  logic [15:0] addrOut;
  logic        m1N, mreqN, rdN, rfshN, fetchDone;
  logic [7:0]  opcodeOut;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] expR = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  ofr_top u_ofr_top (
    .clk(clk), .rstN(rstN), .startFetch(startFetch), .pcIn(pcIn),
    .vecIn(vecIn), .rLoadEn(rLoadEn), .rLoadVal(rLoadVal), .dataIn(dataIn),
    .addrOut(addrOut), .m1N(m1N), .mreqN(mreqN), .rdN(rdN), .rfshN(rfshN),
    .opcodeOut(opcodeOut), .fetchDone(fetchDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Move to 5 ns after the next rising edge.
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // Runs one fetch from idle or T4; returns in the second half of T4.
  task automatic fetchCycle(input logic [15:0] pc, input logic [7:0] op,
                            input bit pokeStart, input bit doLoad, input logic [7:0] loadV);
    rLoadEn = 1'b0;
    pcIn = pc; startFetch = 1'b1; dataIn = 8'h00;
    tick(); // T1, first half
    startFetch = 1'b0; pcIn = ~pc;
    chk("R2 addr in T1", addrOut, pc);
    chk("R3 m1 low in T1", m1N, 0);
    chk("R11 start taken", m1N, 0);
    chk("R4 mreq high early T1", mreqN, 1);
    chk("R4 rd high early T1", rdN, 1);
    chk("R6 rfsh high in T1", rfshN, 1);
    #10;
    chk("R4 mreq low late T1", mreqN, 0);
    chk("R4 rd low late T1", rdN, 0);
    tick(); // T2
    dataIn = op;
    chk("R2 addr in T2", addrOut, pc);
    chk("R3 m1 low in T2", m1N, 0);
    chk("R4 mreq low T2", mreqN, 0);
    chk("R4 rd low T2", rdN, 0);
    if (pokeStart) begin startFetch = 1'b1; pcIn = 16'h1234; end
    tick(); // T3, first half
    startFetch = 1'b0; dataIn = ~op;
    chk("R5 opcode captured", opcodeOut, op);
    chk("R3 m1 high in T3", m1N, 1);
    chk("R7 rd high T3", rdN, 1);
    chk("R7 mreq high early T3", mreqN, 1);
    chk("R6 rfsh low T3", rfshN, 0);
    chk("R6 refresh address T3", addrOut, {vecIn, expR});
    chk("R11 no done in T3", fetchDone, 0);
    #10;
    chk("R7 mreq low late T3", mreqN, 0);
    tick(); // T4, first half
    chk("R7 mreq low early T4", mreqN, 0);
    chk("R11 done in T4", fetchDone, 1);
    chk("R5 opcode held", opcodeOut, op);
    chk("R6 rfsh low T4", rfshN, 0);
    chk("R6 refresh address T4", addrOut, {vecIn, expR});
    if (doLoad) begin rLoadEn = 1'b1; rLoadVal = loadV; end
    #10;
    chk("R7 mreq high late T4", mreqN, 1);
    chk("R7 rd high late T4", rdN, 1);
    expR = doLoad ? loadV : {expR[7], expR[6:0] + 7'd1};
  endtask

  task automatic finishIdle();
    tick();
    rLoadEn = 1'b0;
    chk("R11 done drops", fetchDone, 0);
    chk("R3 m1 high idle", m1N, 1);
    chk("R12 no extra fetch", m1N, 1);
    chk("R6 rfsh high idle", rfshN, 1);
    chk("R4 mreq high idle", mreqN, 1);
  endtask

  task automatic loadR(input logic [7:0] v);
    rLoadEn = 1'b1; rLoadVal = v;
    tick();
    rLoadEn = 1'b0;
    expR = v;
  endtask

  task automatic tReset();
    chk("R1 addr", addrOut, 0);
    chk("R1 m1", m1N, 1);
    chk("R1 mreq", mreqN, 1);
    chk("R1 rd", rdN, 1);
    chk("R1 rfsh", rfshN, 1);
    chk("R1 done", fetchDone, 0);
  endtask

  task automatic tBasic();
    vecIn = 8'hA5;
    fetchCycle(16'h0100, 8'h3E, 0, 0, 8'h00); finishIdle();  // R1: counter starts at 0
    vecIn = 8'h3C;
    fetchCycle(16'hFFFF, 8'h00, 0, 0, 8'h00); finishIdle();
    chk("R8 step count", expR, 8'h02);
  endtask

  task automatic tBit7Kept();
    loadR(8'hFE);  // R9
    fetchCycle(16'h0200, 8'hC3, 0, 0, 8'h00); finishIdle();
    fetchCycle(16'h0201, 8'h76, 0, 0, 8'h00); finishIdle();  // shows FF
    fetchCycle(16'h0202, 8'hED, 0, 0, 8'h00); finishIdle();  // R8: shows 80
  endtask

  task automatic tLowWrap();
    loadR(8'h7F);  // R9 with bit 7 clear
    fetchCycle(16'h4000, 8'h11, 0, 0, 8'h00); finishIdle();
    fetchCycle(16'h4001, 8'h22, 0, 0, 8'h00); finishIdle();  // R8: shows 00
  endtask

  task automatic tCollide();
    fetchCycle(16'h5000, 8'h99, 0, 1, 8'h55); finishIdle();  // R10
    fetchCycle(16'h5001, 8'h98, 0, 0, 8'h00); finishIdle();  // shows 55
  endtask

  task automatic tIgnoreStart();
    fetchCycle(16'h6000, 8'hF3, 1, 0, 8'h00); finishIdle();  // R12
  endtask

  task automatic tBackToBack();
    vecIn = 8'h81;
    fetchCycle(16'h7000, 8'h01, 0, 0, 8'h00);
    fetchCycle(16'h7001, 8'h02, 0, 0, 8'h00);  // R11: T1 follows T4 directly
    fetchCycle(16'h7002, 8'h03, 0, 0, 8'h00);
    finishIdle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #25;
    tReset();
    #10 rstN = 1'b1;
    tick();
    tReset();
    tBasic();
    tBit7Kept();
    tLowWrap();
    tCollide();
    tIgnoreStart();
    tBackToBack();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule